// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable behavioural model of a single-port synchronous SRAM. It is built so that a read and a write can follow each other on consecutive clocks without an idle slot on the data bus. Every accepted command is registered on a rising clock edge, and its data moves in the cycle after that edge. Read data is flow-through: it comes combinationally out of the array during the data cycle, with no output register.

The array holds 18-bit words made of two 9-bit bytes. The address input is split in two: the two lowest bits pick a beat inside an aligned group of four words, and the upper bits stay fixed for the whole burst. A load command starts a new access at the presented address. An advance command steps an internal beat counter, so one load can serve up to four beats, in linear or interleaved order. Three chip enables of mixed polarity gate new commands. An active-low clock enable freezes the whole pipeline. An asynchronous active-low output enable can drop the data-drive signal at any moment. The pad-level bidirectional bus is replaced by separate `wdata`, `rdata` and `rdata_drive` signals.

The data path is a fixed-latency memory bus and has no valid/ready handshake: the command pins carry no back-pressure, and `clk_en_n` is the only way to hold the pipeline. The `rst_n` input clears the command pipeline only. Memory contents are never reset.

Top module: `zt_sram`

## Requirements
- R1: A load (`adv_ld`=0) with all chip enables active and `rd_wr`=1 is captured on a rising edge. In the next cycle, `rdata` shows the stored word at that address and `rdata_drive` is 1, provided `out_en_n` is 0.
- R2: A read may directly follow a write on the next clock, and a write may directly follow a read, with no idle cycle between them. A read of the address written by the immediately preceding write command returns the newly written data.
- R3: While `clk_en_n` is 1, all other synchronous inputs are ignored. Every pipeline register and the array keep their values, so `rdata` and `rdata_drive` stay unchanged and no write is performed.
- R4: A load with `sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1 starts no operation. A transfer already in its data cycle still completes, and a pending write is still committed.
- R5: `rdata_drive` is 0 in the cycle after a write command is accepted and in the cycle after a deselecting load.
- R6: With `burst_ilv`=0 captured at load, each advance gives the address whose upper bits equal those of the loaded address. Its low two bits are (loaded low bits + beat number) mod 4, and the beat number counts 1, 2, 3, 0 and so on.
- R7: With `burst_ilv`=1 captured at load, each advance gives low two bits equal to the loaded low bits XOR the beat number. The upper bits are unchanged.
- R8: An advance repeats the read/write type of the most recent load. If that load was a deselect, the advance performs no transfer: `rdata_drive` stays 0 and nothing is written.
- R9: `byte_wr_n` is sampled with each accepted command, and a 0 bit enables that byte. Bit 0 covers word bits 8:0 and bit 1 covers word bits 17:9. In the write data cycle, only enabled bytes take `wdata`, which is sampled on the edge that ends the data cycle.
- R10: `out_en_n`=1 forces `rdata_drive` to 0 combinationally and does not disturb the pipeline. Driving it back to 0 within the same data cycle restores the drive.
- R11: While `rst_n` is 0 at a rising edge, any pending operation is cancelled, so `rdata_drive` is 0 after that edge. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low pipeline clear |
| clk_en_n | input | 1 | Active-low clock enable; 1 stalls everything |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| rd_wr | input | 1 | 1 read, 0 write (used on load) |
| byte_wr_n | input | NUM_BYTES | Active-low byte write enables |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| addr | input | AW | Word address |
| wdata | input | WORD_W | Write data for the command in its data cycle |
| rdata | output | WORD_W | Flow-through read data |
| rdata_drive | output | 1 | High when the bus would be driven with read data |

## Verification
The bench aims at the turnaround cases: a read issued on the clock right after a write to the same address, where a design that committed the write late would return stale data. Stall cycles are inserted while a read or a write is pending and while conflicting commands are presented. A design that let a stalled edge through would move the output early or write garbage. Each of the three chip enables is deasserted on its own, in turn, right after a pending write and followed by an advance. A design that cancelled the pending transfer, or that let the advance reuse the earlier write, would corrupt a word that the bench later reads back. Every start offset is swept in both burst orders, which exposes wrong carry into the upper bits or an order swap, and every byte-enable combination is swept so that a wrong byte lane shows up.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic valid;
    logic write;
  } zt_op_t;
endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq #(
  parameter int BW = 2
) (
  input  logic [BW-1:0] start,
  input  logic [BW-1:0] beat,
  input  logic          ilv,
  output logic [BW-1:0] idx
);
  // linear wraps inside the group; interleaved flips bits by beat
  assign idx = ilv ? (start ^ beat) : (start + beat);
endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
  import zt_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          load,
  input  logic          sel_ok,
  input  logic          is_read,
  input  logic [NB-1:0] be_n,
  input  logic          ilv,
  input  logic [AW-1:0] addr,
  output zt_op_t        pend_op,
  output logic [AW-1:0] pend_addr,
  output logic [NB-1:0] pend_be_n
);
  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nx;
  logic [BEAT_W-1:0] low_nx;
  logic              ilv_q;
  zt_op_t            ld_op_q;
  zt_op_t            new_op;

  assign beat_nx = beat_q + 1'b1;
  assign new_op  = '{valid: sel_ok, write: ~is_read};

  zt_burst_seq #(.BW(BEAT_W)) i_seq (
    .start (base_q[BEAT_W-1:0]),
    .beat  (beat_nx),
    .ilv   (ilv_q),
    .idx   (low_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      beat_q    <= '0;
      ilv_q     <= 1'b0;
      ld_op_q   <= '0;
      pend_op   <= '0;
      pend_addr <= '0;
      pend_be_n <= '1;
    end else if (!hold) begin
      if (load) begin
        base_q    <= addr;
        beat_q    <= '0;
        ilv_q     <= ilv;
        ld_op_q   <= new_op;
        pend_op   <= new_op;
        pend_addr <= addr;
      end else begin
        beat_q    <= beat_nx;
        pend_op   <= ld_op_q;
        pend_addr <= {base_q[AW-1:BEAT_W], low_nx};
      end
      pend_be_n <= be_n;
    end
  end
endmodule

// File: rtl/zt_byte_mem.sv
module zt_byte_mem #(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int NB     = 2,
  parameter int BYTE_W = 9,
  localparam int DW    = NB * BYTE_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [NB-1:0] be_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYTE_W-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !be_n[g]) lane[addr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = lane[addr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2,
  localparam int AW       = $clog2(DEPTH),
  localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_en_n,
  input  logic                 sel_a_n,
  input  logic                 sel_b,
  input  logic                 sel_c_n,
  input  logic                 adv_ld,
  input  logic                 rd_wr,
  input  logic [NUM_BYTES-1:0] byte_wr_n,
  input  logic                 burst_ilv,
  input  logic                 out_en_n,
  input  logic [AW-1:0]        addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic                 rdata_drive
);
  zt_op_t                 pend_op;
  logic [AW-1:0]          pend_addr;
  logic [NUM_BYTES-1:0]   pend_be_n;
  logic                   sel_ok;
  logic                   commit;

  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

  zt_cmd_pipe #(.AW(AW), .NB(NUM_BYTES)) i_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (clk_en_n),
    .load      (~adv_ld),
    .sel_ok    (sel_ok),
    .is_read   (rd_wr),
    .be_n      (byte_wr_n),
    .ilv       (burst_ilv),
    .addr      (addr),
    .pend_op   (pend_op),
    .pend_addr (pend_addr),
    .pend_be_n (pend_be_n)
  );

  // write lands on the edge that closes the data cycle
  assign commit = rst_n & ~clk_en_n & pend_op.valid & pend_op.write;

  zt_byte_mem #(.DEPTH(DEPTH), .AW(AW), .NB(NUM_BYTES), .BYTE_W(BYTE_W)) i_mem (
    .clk   (clk),
    .we    (commit),
    .be_n  (pend_be_n),
    .addr  (pend_addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  assign rdata_drive = pend_op.valid & ~pend_op.write & ~out_en_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          adv_ld,
  input logic          rd_wr,
  input logic          out_en_n,
  input logic [DW-1:0] rdata,
  input logic          rdata_drive
);
  // R1
  read_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && rd_wr && !sel_a_n && sel_b && !sel_c_n)
      |=> (out_en_n || rdata_drive));

  // R3
  stall_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(rdata));

  // R3
  stall_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !out_en_n) |=> (out_en_n || $stable(rdata_drive)));

  // R4
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && (sel_a_n || !sel_b || sel_c_n)) |=> !rdata_drive);

  // R5
  write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && !rd_wr) |=> !rdata_drive);

  // R10
  oe_gate_chk: assert property (@(posedge clk) out_en_n |-> !rdata_drive);

  // R11
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !rdata_drive);
endmodule

bind zt_sram zt_sram_chk #(.DW(WORD_W)) i_chk (.*);

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int DW    = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b0;
  logic          sel_a_n = 1'b0;
  logic          sel_b = 1'b1;
  logic          sel_c_n = 1'b0;
  logic          adv_ld = 1'b0;
  logic          rd_wr = 1'b1;
  logic [1:0]    byte_wr_n = 2'b00;
  logic          burst_ilv = 1'b0;
  logic          out_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_drive;

  int total = 0;
  int bad   = 0;

  // bench reference state
  logic [DW-1:0] ref_mem [DEPTH];
  bit       m_valid = 0, m_write = 0, m_ldv = 0, m_ldw = 0, m_ilv = 0;
  int       m_addr = 0, m_base = 0, m_beat = 0;
  bit [1:0] m_be = 2'b11;

  always #10 clk = ~clk;

  zt_sram i_zt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .adv_ld(adv_ld), .rd_wr(rd_wr), .byte_wr_n(byte_wr_n),
    .burst_ilv(burst_ilv), .out_en_n(out_en_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  function automatic logic [DW-1:0] pat(input int a);
    int v;
    v = (a * 613 + 77) ^ (a << 9) ^ 'h15A5A;
    return v[DW-1:0];
  endfunction

  task automatic chk(input string tag, input bit ok, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic out_chk(input string tag);
    bit ed;
    ed = m_valid && !m_write && !out_en_n;
    chk(tag, rdata_drive === ed, {17'd0, rdata_drive}, {17'd0, ed});
    if (ed) chk(tag, rdata === ref_mem[m_addr], rdata, ref_mem[m_addr]);
  endtask

  // one clock: drive inputs, update reference at edge, check at negedge
  task automatic tick(input bit cen, input bit adv, input bit rd,
                      input bit san, input bit sb, input bit scn,
                      input bit [1:0] be, input bit ilv, input int a,
                      input logic [DW-1:0] wd, input string tag);
    bit ok;
    int low;
    clk_en_n = cen; adv_ld = adv; rd_wr = rd;
    sel_a_n = san; sel_b = sb; sel_c_n = scn;
    byte_wr_n = be; burst_ilv = ilv; addr = AW'(a); wdata = wd;
    @(posedge clk);
    if (!rst_n) begin
      m_valid = 0; m_ldv = 0; m_beat = 0;
    end else if (!cen) begin
      if (m_valid && m_write) begin
        if (!m_be[0]) ref_mem[m_addr][8:0]  = wd[8:0];
        if (!m_be[1]) ref_mem[m_addr][17:9] = wd[17:9];
      end
      ok = !san && sb && !scn;
      if (!adv) begin
        m_base = a; m_beat = 0; m_ilv = ilv;
        m_ldv = ok; m_ldw = !rd;
        m_valid = ok; m_write = !rd; m_addr = a;
      end else begin
        m_beat = (m_beat + 1) % 4;
        m_valid = m_ldv; m_write = m_ldw;
        low = m_ilv ? ((m_base % 4) ^ m_beat) : ((m_base % 4 + m_beat) % 4);
        m_addr = (m_base / 4) * 4 + low;
      end
      m_be = be;
    end
    @(negedge clk);
    out_chk(tag);
  endtask

  task automatic ld(input bit rd, input int a, input logic [DW-1:0] wd, input string tag);
    tick(0, 0, rd, 0, 1, 0, 2'b00, 0, a, wd, tag);
  endtask

  task automatic ldx(input bit rd, input int a, input bit [1:0] be, input bit ilv,
                     input logic [DW-1:0] wd, input string tag);
    tick(0, 0, rd, 0, 1, 0, be, ilv, a, wd, tag);
  endtask

  task automatic adv(input logic [DW-1:0] wd, input string tag);
    tick(0, 1, 1, 0, 1, 0, 2'b00, 0, 0, wd, tag);
  endtask

  task automatic desel(input int k, input int a, input logic [DW-1:0] wd, input string tag);
    tick(0, 0, 1, k == 0, k != 1, k == 2, 2'b00, 0, a, wd, tag);
  endtask

  task automatic stall(input int a, input logic [DW-1:0] wd, input string tag);
    tick(1, 0, 0, 0, 1, 0, 2'b00, 1, a, wd, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11 reset state
    @(negedge clk);
    tick(0, 0, 1, 0, 1, 0, 2'b00, 0, 3, '0, "R11");
    rst_n = 1'b1;

    // fill every word with back-to-back writes (R2, R5)
    for (int a = 0; a < DEPTH; a++) ld(0, a, (a == 0) ? '0 : pat(a - 1), "R5");
    ld(1, 0, pat(DEPTH - 1), "R2");
    // sweep reads back to back (R1)
    for (int a = 1; a < DEPTH; a++) ld(1, a, '0, "R1");

    // write then read same address on the next clock (R2)
    for (int a = 200; a < 216; a++) begin
      ld(0, a, '0, "R2");
      ld(1, a, ~pat(a), "R2");
    end

    // burst orders, every start offset (R6, R7, R8)
    for (int il = 0; il < 2; il++)
      for (int s = 0; s < 4; s++) begin
        ldx(1, 64 + 4 * s + s, 2'b00, il[0], '0, il ? "R7" : "R6");
        for (int b = 0; b < 4; b++) adv('0, il ? "R7" : "R6");
      end
    ldx(0, 130, 2'b00, 1, '0, "R8");
    for (int b = 0; b < 4; b++) adv(pat(1000 + b), "R8");
    for (int a = 128; a < 132; a++) ld(1, a, (a == 128) ? pat(1003) : '0, "R7");

    // byte write enables (R9)
    for (int b = 0; b < 4; b++) begin
      ldx(0, 20 + b, 2'(b), 0, '0, "R9");
      ld(1, 20 + b, 18'h3FFFF ^ pat(b), "R9");
    end

    // stalls with a pending read and a pending write (R3)
    ld(1, 5, '0, "R3");
    stall(5, 18'h0BEEF, "R3");
    stall(6, 18'h1CAFE, "R3");
    ld(0, 7, '0, "R3");
    stall(8, 18'h12345, "R3");
    ld(1, 7, 18'h2A5A5, "R3");
    ld(1, 5, '0, "R3");
    ld(1, 8, '0, "R3");

    // deselect on each enable: pending completes, advance does nothing (R4, R5, R8)
    for (int k = 0; k < 3; k++) begin
      ld(1, 30 + k, '0, "R4");
      desel(k, 33, '0, "R4");
      ld(0, 40 + 4 * k, '0, "R4");
      desel(k, 41 + 4 * k, pat(500 + k), "R5");
      adv(18'h3FFFF, "R8");
      ld(1, 40 + 4 * k, '0, "R4");
      ld(1, 42 + 4 * k, '0, "R8");
    end

    // output enable is asynchronous (R10)
    ld(1, 9, '0, "R10");
    out_en_n = 1'b1; #1;
    chk("R10", rdata_drive === 1'b0, {17'd0, rdata_drive}, '0);
    out_en_n = 1'b0; #1;
    chk("R10", rdata_drive === 1'b1, {17'd0, rdata_drive}, 18'd1);
    tick(0, 0, 1, 0, 1, 0, 2'b00, 0, 10, '0, "R10");
    out_en_n = 1'b1;
    tick(0, 0, 1, 0, 1, 0, 2'b00, 0, 11, '0, "R10");
    out_en_n = 1'b0; #1;
    out_chk("R10");

    // reset mid-burst keeps the array (R11)
    ld(1, 12, '0, "R11");
    rst_n = 1'b0;
    adv('0, "R11");
    rst_n = 1'b1;
    adv('0, "R11");
    ld(1, 12, '0, "R11");
    ld(1, 13, '0, "R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule